// File: doc/BRIEF.md
# Low-Power Stop and Wake-Up Sequencer

This block moves a microcontroller core into and out of a low-power stop state. It has two variants of that state. The RC-watchdog variant shuts the main crystal oscillator off and leaves an internal RC oscillator running so that a watchdog can still fire. The plain variant shuts both oscillators off. Both variants are entered from a CPU stop request. The variant is chosen by a two-bit mode field in a control byte. While stopped, registers and memory keep their contents and the CPU clock is gated off.

A wake-up never hands the clock straight back to the CPU. When a wake source arrives, the main oscillator is switched back on, and an 8-bit stabilization counter starts from zero. The counter advances once per prescaled tick, and the CPU clock is released only when it overflows past FFh. The prescaler ratio is programmable, so the wait can be set longer than the oscillator start-up time (20 ms is the usual target).

On release, the block gives one wake action as a one-cycle pulse. The action is one of: resume after the stop, vector to the external interrupt, vector to the watchdog interrupt, or an internal reset. Which action is given depends on the wake source, the CPU interrupt-enable flag, the watchdog interrupt enable and a watchdog-reset select bit.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: A stop request while the control mode field (bits 2:1) reads 2'b01 enters the RC-watchdog stop state. One cycle later osc_en=0, rc_en=1 and cpu_clk_en=0.
- R2: A stop request with any other mode field value enters a plain stop state with osc_en=0 and rc_en=0. In the plain stop state wdt_evt is ignored, and only ext_irq wakes the block.
- R3: Once stopped, the block stays stopped until hardware reset, ext_irq, or (in the RC-watchdog state) wdt_evt. Further stop requests have no effect.
- R4: The wake edge turns osc_en back on and clears stab_cnt to 00h. stab_cnt then counts up once every 2<<S clock cycles, where S is the 3-bit prescaler field in control bits 5:3 (S=0 gives 2, S=7 gives 256). cpu_clk_en rises on the edge that makes stab_cnt overflow from FFh to 00h, which is 256*(2<<S) edges after the wake edge.
- R5: The prescaler field is captured when the stop is accepted. Control writes made while the block is stopped do not change the stabilization length.
- R6: A wake caused by ext_irq pulses wake_vec_ext if cpu_ie=1, and pulses wake_resume if cpu_ie=0. The pulse lasts one cycle, in the same cycle that cpu_clk_en rises.
- R7: A wake caused by wdt_evt with cpu_ie=1 pulses int_rst if control bit 0 (watchdog-reset select) is 1. Otherwise it pulses wake_vec_wdt if wdt_ie=1. An int_rst pulse returns the control byte to 00h.
- R8: A wake caused by wdt_evt with cpu_ie=0 pulses wake_resume and neither vectors nor resets.
- R9: A control write takes effect only when all eight bits of ctl_wr_mask are set. A write with a partial mask leaves the control byte unchanged.
- R10: Synchronous hardware reset leaves any stop state at once. After reset, osc_en=1, cpu_clk_en=1, rc_en=0, stab_cnt=00h, all action pulses are low, and the control byte is 00h.
- R11: If ext_irq and wdt_evt arrive in the same cycle in the RC-watchdog state, the external interrupt is serviced first. The watchdog event is held pending, and its action (decided as in R7) pulses one cycle after the external wake action.
- R12: At most one of wake_resume, wake_vec_ext, wake_vec_wdt and int_rst is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_mask | input | 8 | Per-bit write mask; the write is accepted only when all bits are 1 |
| ctl_wr_data | input | 8 | Control byte: bit0 watchdog-reset select, bits 2:1 mode, bits 5:3 prescaler |
| stop_req | input | 1 | CPU stop request |
| ext_irq | input | 1 | External interrupt wake source |
| wdt_evt | input | 1 | Watchdog event from the RC-clocked watchdog |
| cpu_ie | input | 1 | CPU global interrupt-enable flag |
| wdt_ie | input | 1 | Watchdog interrupt enable |
| osc_en | output | 1 | Main oscillator enable |
| rc_en | output | 1 | RC oscillator / watchdog run enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| stab_cnt | output | 8 | Stabilization counter value |
| wake_resume | output | 1 | Pulse: resume after the stop, no vector |
| wake_vec_ext | output | 1 | Pulse: vector to the external interrupt |
| wake_vec_wdt | output | 1 | Pulse: vector to the watchdog interrupt |
| int_rst | output | 1 | Pulse: internal reset |

## Verification
Some behaviour is checked by the assertions on every cycle. These checks cover: oscillator exclusivity while the RC-watchdog state is held; the CPU clock gate falling only after a stop request; the counter being cleared on entry and advancing by at most one per cycle; ignored partial writes; external-first priority on a simultaneous wake; and at most one wake action per cycle. Other behaviour can only be shown by the bench's scenarios. These are: the exact release cycle for each prescaler setting; the prescaler being captured at stop entry; the action chosen for each combination of interrupt flag, enable and reset select; the delivery of a pending watchdog event; and the control byte returning to its default after an internal reset.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int CTL_W      = 8;
  localparam int CTL_RSEL   = 0;
  localparam int CTL_MODE_L = 1;
  localparam int CTL_PSEL_L = 3;
  localparam logic [1:0] MODE_RCWDT = 2'b01;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PSTOP,
    ST_RCW,
    ST_STAB
  } lpw_state_e;

  typedef enum logic [1:0] {
    ACT_RESUME,
    ACT_VEXT,
    ACT_VWDT,
    ACT_IRST
  } lpw_act_e;
endpackage

// File: rtl/lpw_ctl_reg.sv
module lpw_ctl_reg
  import lpw_pkg::*;
#(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_mask,
  input  logic [CTL_W-1:0]  wr_data,
  output logic              mode_rc,
  output logic              rst_sel,
  output logic [PSEL_W-1:0] psel
);
  logic [CTL_W-1:0] ctl_q;
  logic             full_wr;

  assign full_wr = wr_en && (&wr_mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctl_q <= '0;
    end else if (full_wr) begin
      ctl_q <= wr_data;
    end
  end

  assign mode_rc = (ctl_q[CTL_MODE_L +: 2] == MODE_RCWDT);
  assign rst_sel = ctl_q[CTL_RSEL];
  assign psel    = ctl_q[CTL_PSEL_L +: PSEL_W];

  // R9: byte-incomplete writes must not disturb the register
  assert_partial_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&wr_mask) && !clr) |=> $stable(ctl_q));
endmodule

// File: rtl/lpw_stab_timer.sv
module lpw_stab_timer #(
  parameter int CNT_W  = 8,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic [PSEL_W-1:0] psel_in,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf
);
  localparam int PRE_W = 2 ** PSEL_W;

  logic [PSEL_W-1:0] psel_q;
  logic [PRE_W-1:0]  pc;
  logic [PRE_W:0]    ratio;
  logic [PRE_W-1:0]  lim;
  logic              tick;

  assign ratio = (PRE_W+1)'(2) << psel_q;
  assign lim   = PRE_W'(ratio - 1'b1);
  assign tick  = run && (pc == lim);
  assign ovf   = tick && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      psel_q <= '0;
    end else if (load) begin
      psel_q <= psel_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc  <= '0;
      cnt <= '0;
    end else if (tick) begin
      pc  <= '0;
      cnt <= cnt + 1'b1;
    end else begin
      pc  <= pc + 1'b1;
    end
  end

  // R4: counting starts from zero when stabilization begins
  assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0 && pc == '0));

  // R4: the stabilization counter advances by at most one per cycle
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R5: the captured ratio stays fixed while stabilizing
  assert_psel_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(psel_q));
endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm
  import lpw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic ext_irq,
  input  logic wdt_evt,
  input  logic cpu_ie,
  input  logic wdt_ie,
  input  logic mode_rc,
  input  logic rst_sel,
  input  logic ovf,
  output logic osc_en,
  output logic rc_en,
  output logic clk_en,
  output logic stab_run,
  output logic in_run,
  output logic resume,
  output logic vec_ext,
  output logic vec_wdt,
  output logic int_rst
);
  lpw_state_e st;
  lpw_act_e   act;
  logic       wpend;

  assign stab_run = (st == ST_STAB);
  assign in_run   = (st == ST_RUN);

  function automatic lpw_act_e wdt_action(input logic ie, input logic rs,
                                          input logic we);
    if (!ie)      return ACT_RESUME;
    else if (rs)  return ACT_IRST;
    else if (we)  return ACT_VWDT;
    else          return ACT_RESUME;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_RUN;
      act     <= ACT_RESUME;
      wpend   <= 1'b0;
      osc_en  <= 1'b1;
      rc_en   <= 1'b0;
      clk_en  <= 1'b1;
      resume  <= 1'b0;
      vec_ext <= 1'b0;
      vec_wdt <= 1'b0;
      int_rst <= 1'b0;
    end else begin
      resume  <= 1'b0;
      vec_ext <= 1'b0;
      vec_wdt <= 1'b0;
      int_rst <= 1'b0;
      unique case (st)
        ST_RUN: begin
          if (wpend) begin
            wpend <= 1'b0;
            unique case (wdt_action(cpu_ie, rst_sel, wdt_ie))
              ACT_IRST: int_rst <= 1'b1;
              ACT_VWDT: vec_wdt <= 1'b1;
              default:  ;
            endcase
          end else if (stop_req) begin
            clk_en <= 1'b0;
            osc_en <= 1'b0;
            if (mode_rc) begin
              st    <= ST_RCW;
              rc_en <= 1'b1;
            end else begin
              st <= ST_PSTOP;
            end
          end
        end
        ST_PSTOP: begin
          if (ext_irq) begin
            st     <= ST_STAB;
            osc_en <= 1'b1;
            act    <= cpu_ie ? ACT_VEXT : ACT_RESUME;
          end
        end
        ST_RCW: begin
          if (ext_irq) begin
            st     <= ST_STAB;
            osc_en <= 1'b1;
            rc_en  <= 1'b0;
            act    <= cpu_ie ? ACT_VEXT : ACT_RESUME;
            wpend  <= wdt_evt;
          end else if (wdt_evt) begin
            st     <= ST_STAB;
            osc_en <= 1'b1;
            rc_en  <= 1'b0;
            act    <= wdt_action(cpu_ie, rst_sel, wdt_ie);
          end
        end
        ST_STAB: begin
          if (ovf) begin
            st     <= ST_RUN;
            clk_en <= 1'b1;
            unique case (act)
              ACT_RESUME: resume  <= 1'b1;
              ACT_VEXT:   vec_ext <= 1'b1;
              ACT_VWDT:   vec_wdt <= 1'b1;
              ACT_IRST:   int_rst <= 1'b1;
            endcase
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  // R1: main and RC oscillators never both enabled while in RC-watchdog stop
  assert_rc_excl_R1: assert property (@(posedge clk) disable iff (rst)
    rc_en |-> !osc_en);

  // R3: the CPU clock gate only closes in response to a stop request
  assert_gate_on_stop_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> $past(stop_req));

  // R11: simultaneous wake sources are resolved external-first
  assert_ext_first_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RCW && ext_irq && wdt_evt) |=> (wpend && (act == ACT_VEXT || act == ACT_RESUME)));

  // R12: wake actions are mutually exclusive
  assert_one_action_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume, vec_ext, vec_wdt, int_rst}));
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PSEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_mask,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             stop_req,
  input  logic             ext_irq,
  input  logic             wdt_evt,
  input  logic             cpu_ie,
  input  logic             wdt_ie,
  output logic             osc_en,
  output logic             rc_en,
  output logic             cpu_clk_en,
  output logic [CNT_W-1:0] stab_cnt,
  output logic             wake_resume,
  output logic             wake_vec_ext,
  output logic             wake_vec_wdt,
  output logic             int_rst
);
  logic              mode_rc;
  logic              rst_sel;
  logic [PSEL_W-1:0] psel;
  logic              stab_run;
  logic              in_run;
  logic              ovf;

  lpw_ctl_reg #(.PSEL_W(PSEL_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .clr     (int_rst),
    .wr_en   (ctl_wr_en),
    .wr_mask (ctl_wr_mask),
    .wr_data (ctl_wr_data),
    .mode_rc (mode_rc),
    .rst_sel (rst_sel),
    .psel    (psel)
  );

  lpw_stab_timer #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (stab_run),
    .load    (in_run),
    .psel_in (psel),
    .cnt     (stab_cnt),
    .ovf     (ovf)
  );

  lpw_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .ext_irq  (ext_irq),
    .wdt_evt  (wdt_evt),
    .cpu_ie   (cpu_ie),
    .wdt_ie   (wdt_ie),
    .mode_rc  (mode_rc),
    .rst_sel  (rst_sel),
    .ovf      (ovf),
    .osc_en   (osc_en),
    .rc_en    (rc_en),
    .clk_en   (cpu_clk_en),
    .stab_run (stab_run),
    .in_run   (in_run),
    .resume   (wake_resume),
    .vec_ext  (wake_vec_ext),
    .vec_wdt  (wake_vec_wdt),
    .int_rst  (int_rst)
  );
endmodule

// File: tb/lpw_wake_ctrl_bench.sv
module lpw_wake_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_mask = '0;
  logic [7:0] ctl_wr_data = '0;
  logic       stop_req = 1'b0;
  logic       ext_irq = 1'b0;
  logic       wdt_evt = 1'b0;
  logic       cpu_ie = 1'b0;
  logic       wdt_ie = 1'b0;
  logic       osc_en, rc_en, cpu_clk_en;
  logic [7:0] stab_cnt;
  logic       wake_resume, wake_vec_ext, wake_vec_wdt, int_rst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpw_wake_ctrl u_lpw_wake_ctrl (
    .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_mask(ctl_wr_mask),
    .ctl_wr_data(ctl_wr_data), .stop_req(stop_req), .ext_irq(ext_irq),
    .wdt_evt(wdt_evt), .cpu_ie(cpu_ie), .wdt_ie(wdt_ie), .osc_en(osc_en),
    .rc_en(rc_en), .cpu_clk_en(cpu_clk_en), .stab_cnt(stab_cnt),
    .wake_resume(wake_resume), .wake_vec_ext(wake_vec_ext),
    .wake_vec_wdt(wake_vec_wdt), .int_rst(int_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] s, input logic [1:0] m, input logic r);
    return {2'b00, s, m, r};
  endfunction

  task automatic write_ctl(input logic [7:0] d, input logic [7:0] msk);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_mask = msk; ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_mask = '0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  // drive wake inputs for one edge, return edges until cpu_clk_en rises;
  // acts holds {resume, vec_ext, vec_wdt, int_rst} sampled at release
  task automatic wake(input logic e, input logic w, output int n, output logic [3:0] acts,
                      input int mid_n, output int mid_cnt);
    @(negedge clk);
    ext_irq = e; wdt_evt = w;
    n = 0; mid_cnt = -1;
    do begin
      @(negedge clk);
      ext_irq = 1'b0; wdt_evt = 1'b0;
      n++;
      if (n == mid_n) mid_cnt = int'(stab_cnt);
    end while (!cpu_clk_en && n < 5000);
    acts = {wake_resume, wake_vec_ext, wake_vec_wdt, int_rst};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(osc_en == 1'b1 && cpu_clk_en == 1'b1, "R10 reset clocks", {osc_en, cpu_clk_en}, 3);
    chk(rc_en == 1'b0 && stab_cnt == 8'h00, "R10 reset rc/cnt", {rc_en, stab_cnt}, 0);
    chk({wake_resume, wake_vec_ext, wake_vec_wdt, int_rst} == 4'b0, "R10 reset pulses",
        {wake_resume, wake_vec_ext, wake_vec_wdt, int_rst}, 0);
  endtask

  task automatic t_rc_ext_vec();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b01, 1'b0), 8'hFF);
    do_stop();
    chk(osc_en == 0 && rc_en == 1 && cpu_clk_en == 0, "R1 rc-watchdog entry",
        {osc_en, rc_en, cpu_clk_en}, 3'b010);
    cpu_ie = 1'b1;
    wake(1'b1, 1'b0, n, a, 21, mc);
    chk(n == 513, "R4 release edge S=0", n, 513);
    chk(mc == 10, "R4 stab_cnt mid-count", mc, 10);
    chk(a == 4'b0100, "R6 ext vector with ie=1", a, 4'b0100);
    @(negedge clk);
    chk({wake_resume, wake_vec_ext} == 2'b00, "R6 one-cycle pulse", {wake_resume, wake_vec_ext}, 0);
  endtask

  task automatic t_hold_stop();
    do_stop();
    do_stop();
    repeat (20) @(negedge clk);
    chk(rc_en == 1 && cpu_clk_en == 0 && osc_en == 0, "R3 stays stopped",
        {osc_en, rc_en, cpu_clk_en}, 3'b010);
    do_reset();
    chk(osc_en == 1 && cpu_clk_en == 1 && rc_en == 0, "R10 reset exits stop",
        {osc_en, rc_en, cpu_clk_en}, 3'b101);
  endtask

  task automatic t_psel_latch();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd2, 2'b01, 1'b0), 8'hFF);
    do_stop();
    write_ctl(ctl(3'd0, 2'b01, 1'b0), 8'hFF);
    cpu_ie = 1'b0;
    wake(1'b1, 1'b0, n, a, 0, mc);
    chk(n == 2049, "R5 ratio captured at stop (S=2)", n, 2049);
    chk(a == 4'b1000, "R6 ext resume with ie=0", a, 4'b1000);
  endtask

  task automatic t_plain_stop();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b11, 1'b0), 8'hFF);
    do_stop();
    chk(osc_en == 0 && rc_en == 0 && cpu_clk_en == 0, "R2 plain stop entry",
        {osc_en, rc_en, cpu_clk_en}, 0);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    repeat (3) @(negedge clk);
    chk(osc_en == 0 && cpu_clk_en == 0, "R2 wdt ignored in plain stop",
        {osc_en, cpu_clk_en}, 0);
    cpu_ie = 1'b0;
    wake(1'b1, 1'b0, n, a, 0, mc);
    chk(n == 513 && a == 4'b1000, "R2 ext wakes plain stop", n, 513);
  endtask

  task automatic t_partial_write();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b00, 1'b0), 8'hFF);
    write_ctl(ctl(3'd0, 2'b01, 1'b0), 8'h0F);
    do_stop();
    chk(rc_en == 0 && osc_en == 0, "R9 partial-mask write ignored", rc_en, 0);
    wake(1'b1, 1'b0, n, a, 0, mc);
  endtask

  task automatic t_wdt_vec();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b01, 1'b0), 8'hFF);
    do_stop();
    cpu_ie = 1'b1; wdt_ie = 1'b1;
    wake(1'b0, 1'b1, n, a, 0, mc);
    chk(n == 513 && a == 4'b0010, "R7 wdt vector", a, 4'b0010);
  endtask

  task automatic t_wdt_ie0();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b01, 1'b1), 8'hFF);
    do_stop();
    cpu_ie = 1'b0; wdt_ie = 1'b1;
    wake(1'b0, 1'b1, n, a, 0, mc);
    chk(a == 4'b1000, "R8 wdt wake with ie=0 resumes", a, 4'b1000);
  endtask

  task automatic t_wdt_reset();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b01, 1'b1), 8'hFF);
    do_stop();
    cpu_ie = 1'b1; wdt_ie = 1'b1;
    wake(1'b0, 1'b1, n, a, 0, mc);
    chk(a == 4'b0001, "R7 wdt internal reset", a, 4'b0001);
    do_stop();
    chk(rc_en == 0 && osc_en == 0, "R7 control byte defaulted after int_rst", rc_en, 0);
    wake(1'b1, 1'b0, n, a, 0, mc);
  endtask

  task automatic t_simultaneous();
    int n, mc; logic [3:0] a;
    write_ctl(ctl(3'd0, 2'b01, 1'b0), 8'hFF);
    do_stop();
    cpu_ie = 1'b1; wdt_ie = 1'b1;
    wake(1'b1, 1'b1, n, a, 0, mc);
    chk(n == 513 && a == 4'b0100, "R11 ext serviced first", a, 4'b0100);
    @(negedge clk);
    a = {wake_resume, wake_vec_ext, wake_vec_wdt, int_rst};
    chk(a == 4'b0010, "R11 pending wdt delivered next cycle", a, 4'b0010);
    @(negedge clk);
    a = {wake_resume, wake_vec_ext, wake_vec_wdt, int_rst};
    chk(a == 4'b0000, "R12 no further action", a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_rc_ext_vec();
    t_hold_stop();
    t_psel_latch();
    t_plain_stop();
    t_partial_write();
    t_wdt_vec();
    t_wdt_ie0();
    t_wdt_reset();
    t_simultaneous();
    done = 1'b1;
  end

  initial begin
    wait (done || cyc >= WDOG);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule